// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the slave side of a four-wire serial memory link in SPI mode 0 or mode 3. Its target is a 512-byte nonvolatile store, modelled here as an internal register file. The pins SCK, SI and chip select are oversampled by the faster system clock. Inside the block they pass through two-flop synchronizers and edge detectors. A state machine takes a command byte, then any address and data bytes, most significant bit first. It then streams array or status data back, or gathers page data for a later commit.

The block does not own the write-enable latch, the block protection or the write timer. Those live in a neighbouring protection unit. The engine tells that unit about latch-set and latch-clear commands through one-cycle pulses. A completed write or status write is announced with a one-cycle commit strobe, and the array is updated in that same cycle only if the unit's grant input is high. The unit also supplies the status byte and the write-in-progress flag. The output pin is modelled as a data bit plus an enable, and the surrounding logic resolves the tri-state.

States: IDLE (deselected), OPC (command byte), ADR (low address byte), RDAT (array streaming), WDAT (page collection), STAT (status streaming), WSR (status byte collection), ARM (waiting for deselect to take effect) and SINK (ignore until deselect). Transitions:
- A falling chip select enters OPC.
- A high chip select returns to IDLE.
- At the end of the command byte, OPC goes to ADR for an array read or write. A read while a write cycle runs goes to SINK instead.
- OPC goes to STAT for a status read, to WSR for a status write, and to ARM for latch set or latch clear. Any other byte sends it to SINK.
- ADR goes to RDAT or WDAT.
- WSR goes to ARM after its byte.
- ARM goes to SINK on any further SCK rise.

Top module: `spi_eeprom_engine`

## Requirements
- R1: When chip select is high, so_oe is low within four clock cycles. A chip select held low through reset starts no command; a command begins only on a high-to-low transition of chip select seen after reset.
- R2: Command byte format 0000_H011 reads the array and 0000_H010 writes it. H (bit 3) is address bit 8, and the next byte gives address bits 7..0. SI is taken on SCK rises. Read data goes out MSB first, with each bit changing after an SCK fall.
- R3: During an array read the address advances after each byte, and 0x1FF is followed by 0x000.
- R4: An array write stores consecutive bytes at offsets within one 16-byte page. Offset 0xF is followed by offset 0x0 of the same page, and later bytes overwrite earlier ones. When chip select rises after a whole number of data bytes, cmt_valid pulses once with cmt_status=0 and cmt_addr equal to the start address.
- R5: A chip select rise in the middle of a byte discards the write. There is no cmt_valid pulse and the array keeps its old contents.
- R6: Byte 0x01 followed by exactly one data byte and a chip select rise pulses cmt_valid with cmt_status=1 and cmt_sdata equal to that byte. A partial byte or an extra bit gives no pulse.
- R7: Byte 0x06 and byte 0x04, each followed by a chip select rise after exactly eight bits, pulse wren_pulse and wrdi_pulse respectively. Any extra bit cancels the pulse. At most one of wren_pulse, wrdi_pulse and cmt_valid is high in any cycle.
- R8: Byte 0x05 streams status_in on SO, repeated for every following byte, whether or not a write cycle is in progress.
- R9: An array read started while wip is high is refused. so_oe stays low for the whole selection.
- R10: Any other command byte is ignored until deselect. so_oe stays low and no pulse is produced.
- R11: With wr_grant low in the commit cycle, cmt_valid still pulses but the array is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable |
| wip | input | 1 | Write cycle in progress, from the write timer |
| status_in | input | 8 | Status byte returned by status reads |
| wr_grant | input | 1 | Protection unit allows the pending commit |
| cmt_valid | output | 1 | One-cycle commit strobe |
| cmt_status | output | 1 | Commit targets the status register |
| cmt_addr | output | 9 | Start address of an array commit |
| cmt_sdata | output | 8 | Status byte of a status commit |
| wren_pulse | output | 1 | Set write-enable latch |
| wrdi_pulse | output | 1 | Clear write-enable latch |

## Verification
The detected chip-select rise does two things in the same cycle. It ends the selection, and it decides whether the collected page is committed, based on the bit count and on wr_grant in that very cycle. The bench sets up both sides of that cycle. It raises chip select on a byte boundary with the grant high and then with it low, and it raises chip select mid-byte and one byte too late. It judges each case by the commit strobe count and by reading the page back over the serial link.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
    localparam int ADDR_W = 9;
    localparam int PAGE_W = 4;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_ADR, ST_RDAT, ST_WDAT,
        ST_STAT, ST_WSR, ST_ARM, ST_SINK
    } eng_state_t;

    typedef enum logic [1:0] {PK_NONE, PK_SETWE, PK_CLRWE, PK_STAT} pend_t;

    localparam logic [7:0] OPC_SETWE  = 8'h06;
    localparam logic [7:0] OPC_CLRWE  = 8'h04;
    localparam logic [7:0] OPC_RDST   = 8'h05;
    localparam logic [7:0] OPC_WRST   = 8'h01;
    localparam logic [7:0] OPC_RD_PAT = 8'h03;
    localparam logic [7:0] OPC_WR_PAT = 8'h02;
    localparam logic [7:0] OPC_HI_MSK = 8'hF7;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic m1, m2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m1 <= 1'b0;
                m2 <= 1'b0;
            end else begin
                m1 <= pin[g];
                m2 <= m1;
            end
        end
        assign lvl[g] = m2;
    end
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int AW = 9,
    parameter int PW = 4
) (
    input  logic                        clk,
    input  logic [AW-1:0]               rd_addr,
    output logic [7:0]                  rd_data,
    input  logic                        wr_en,
    input  logic [AW-PW-1:0]            wr_page,
    input  logic [(1<<PW)-1:0]          wr_mask,
    input  logic [(1<<PW)-1:0][7:0]     wr_bytes
);
    localparam int DEPTH  = 1 << AW;
    localparam int PAGE_N = 1 << PW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int j = 0; j < PAGE_N; j++) begin
                if (wr_mask[j]) mem[{wr_page, j[PW-1:0]}] <= wr_bytes[j];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import spi_eeprom_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          si,
    output logic          so_data,
    output logic          so_oe,
    input  logic          wip,
    input  logic [7:0]    status_in,
    input  logic          wr_grant,
    output logic          cmt_valid,
    output logic          cmt_status,
    output logic [AW-1:0] cmt_addr,
    output logic [7:0]    cmt_sdata,
    output logic          wren_pulse,
    output logic          wrdi_pulse
);
    localparam int PAGE_N = 1 << PW;
    localparam int HI_W   = AW - 8;

    logic [2:0] sy;
    logic cs_l, sck_l, si_l, cs_d, sck_d;
    logic cs_rise, cs_fall, sck_rise, sck_fall;

    spi_pin_sync #(.N(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin({cs_n, sck, si}), .lvl(sy)
    );
    assign {cs_l, sck_l, si_l} = sy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_l;
            sck_d <= sck_l;
        end
    end
    assign cs_rise  = cs_l & ~cs_d;
    assign cs_fall  = ~cs_l & cs_d;
    assign sck_rise = sck_l & ~sck_d;
    assign sck_fall = ~sck_l & sck_d;

    eng_state_t state, nxt;
    pend_t pend;
    logic [2:0] bitcnt;
    logic [7:0] sh, tx, sdat, rx, rd_data;
    logic [AW-1:0] addr, wstart, rd_addr;
    logic [PAGE_N-1:0] pmask;
    logic [PAGE_N-1:0][7:0] pbuf;
    logic op_rd, is_rd, is_wr, arr_fire, arm_fire;

    assign rx    = {sh[6:0], si_l};
    assign is_rd = (rx & OPC_HI_MSK) == OPC_RD_PAT;
    assign is_wr = (rx & OPC_HI_MSK) == OPC_WR_PAT;
    assign rd_addr = (state == ST_ADR) ? {addr[AW-1:8], rx} : addr + 1'b1;

    eeprom_store #(.AW(AW), .PW(PW)) u_mem (
        .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(arr_fire & wr_grant), .wr_page(addr[AW-1:PW]),
        .wr_mask(pmask), .wr_bytes(pbuf)
    );

    // commit decisions, all taken in the cycle the deselect is seen
    assign arr_fire   = cs_rise && state == ST_WDAT && bitcnt == 3'd0 && |pmask;
    assign arm_fire   = cs_rise && state == ST_ARM && bitcnt == 3'd0;
    assign cmt_valid  = arr_fire | (arm_fire & (pend == PK_STAT));
    assign cmt_status = (state == ST_ARM);
    assign cmt_addr   = wstart;
    assign cmt_sdata  = sdat;
    assign wren_pulse = arm_fire & (pend == PK_SETWE);
    assign wrdi_pulse = arm_fire & (pend == PK_CLRWE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (cs_fall)                          nxt = ST_OPC;
        else if (cs_l)                        nxt = ST_IDLE;
        else if (sck_rise && state == ST_ARM) nxt = ST_SINK;
        else if (sck_rise && bitcnt == 3'd7) begin
            unique case (state)
                ST_OPC: begin
                    if (is_rd)                 nxt = wip ? ST_SINK : ST_ADR;
                    else if (is_wr)            nxt = ST_ADR;
                    else if (rx == OPC_RDST)   nxt = ST_STAT;
                    else if (rx == OPC_WRST)   nxt = ST_WSR;
                    else if (rx == OPC_SETWE || rx == OPC_CLRWE) nxt = ST_ARM;
                    else                       nxt = ST_SINK;
                end
                ST_ADR:  nxt = op_rd ? ST_RDAT : ST_WDAT;
                ST_WSR:  nxt = ST_ARM;
                ST_IDLE, ST_RDAT, ST_WDAT, ST_STAT, ST_ARM, ST_SINK: nxt = state;
            endcase
        end
    end

    // datapath and serial output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0; sh <= '0; tx <= '0; sdat <= '0;
            addr <= '0; wstart <= '0; op_rd <= 1'b0;
            pmask <= '0; pbuf <= '0; pend <= PK_NONE;
            so_data <= 1'b0; so_oe <= 1'b0;
        end else begin
            if (cs_l) so_oe <= 1'b0;
            if (cs_fall) begin
                bitcnt <= '0;
                pmask  <= '0;
                pend   <= PK_NONE;
                so_oe  <= 1'b0;
            end else if (!cs_l && sck_rise) begin
                sh     <= rx;
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    unique case (state)
                        ST_OPC: begin
                            addr[AW-1:8] <= rx[3 +: HI_W];
                            op_rd        <= is_rd;
                            tx           <= status_in;
                            if (rx == OPC_SETWE)      pend <= PK_SETWE;
                            else if (rx == OPC_CLRWE) pend <= PK_CLRWE;
                            else if (rx == OPC_WRST)  pend <= PK_STAT;
                        end
                        ST_ADR: begin
                            addr[7:0] <= rx;
                            wstart    <= {addr[AW-1:8], rx};
                            tx        <= rd_data;
                        end
                        ST_RDAT: begin
                            addr <= rd_addr;
                            tx   <= rd_data;
                        end
                        ST_WDAT: begin
                            pbuf[addr[PW-1:0]]  <= rx;
                            pmask[addr[PW-1:0]] <= 1'b1;
                            addr[PW-1:0]        <= addr[PW-1:0] + 1'b1;
                        end
                        ST_STAT: tx   <= status_in;
                        ST_WSR:  sdat <= rx;
                        default: ;
                    endcase
                end
            end else if (!cs_l && sck_fall && (state == ST_RDAT || state == ST_STAT)) begin
                so_data <= tx[~bitcnt];
                so_oe   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_engine_chk.sv
module spi_eeprom_engine_chk
    import spi_eeprom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       so_oe,
    input logic       cmt_valid,
    input logic       wren_pulse,
    input logic       wrdi_pulse,
    input eng_state_t state_q,
    input logic [8:0] addr_q
);
    // R1
    oe_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4)) |-> !so_oe);

    // R10
    oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (state_q == ST_RDAT || state_q == ST_STAT));

    // R7
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_pulse, wrdi_pulse, cmt_valid}));

    // R4
    commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> !cmt_valid);

    // R4
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDAT && $past(state_q) == ST_WDAT) |-> addr_q[8:4] == $past(addr_q[8:4]));
endmodule

bind spi_eeprom_engine spi_eeprom_engine_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe),
    .cmt_valid(cmt_valid), .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse),
    .state_q(state), .addr_q(addr)
);

// File: tb/spi_eeprom_engine_tb.sv
module spi_eeprom_engine_tb_top;
    localparam int HALF = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sck, cs_n, si, wip, wr_grant;
    logic [7:0] status_in;
    logic so_data, so_oe, cmt_valid, cmt_status, wren_pulse, wrdi_pulse;
    logic [8:0] cmt_addr;
    logic [7:0] cmt_sdata;

    spi_eeprom_engine dut_i (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_data(so_data), .so_oe(so_oe), .wip(wip), .status_in(status_in),
        .wr_grant(wr_grant), .cmt_valid(cmt_valid), .cmt_status(cmt_status),
        .cmt_addr(cmt_addr), .cmt_sdata(cmt_sdata),
        .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse)
    );

    int total = 0, bad = 0;
    int n_wren = 0, n_wrdi = 0, n_cmt = 0;
    bit oe_seen = 0;
    logic       last_st;
    logic [8:0] last_addr;
    logic [7:0] last_sd;

    always @(posedge clk) begin
        if (wren_pulse) n_wren++;
        if (wrdi_pulse) n_wrdi++;
        if (cmt_valid) begin
            n_cmt++;
            last_st   = cmt_status;
            last_addr = cmt_addr;
            last_sd   = cmt_sdata;
        end
        if (so_oe) oe_seen = 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wclk(HALF);
        oe_seen = 0;
    endtask

    task automatic desel();
        wclk(HALF);
        cs_n = 1'b1;
        wclk(24);
    endtask

    task automatic xbits(input logic [7:0] b, input int n, output logic [7:0] r);
        r = 8'hxx;
        for (int i = 7; i > 7 - n; i--) begin
            si = b[i];
            wclk(HALF);
            r[i] = so_oe ? so_data : 1'bz;
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        xbits(b, 8, r);
    endtask

    task automatic start_cmd(input logic [8:0] a, input bit rd);
        logic [7:0] r;
        sel();
        xfer({4'b0000, a[8], 2'b01, rd}, r);
        xfer(a[7:0], r);
    endtask

    task automatic write1(input logic [8:0] a, input logic [7:0] d);
        logic [7:0] r;
        start_cmd(a, 1'b0);
        xfer(d, r);
        desel();
    endtask

    task automatic expect_read(input logic [8:0] a, input logic [7:0] exp, input string req);
        logic [7:0] r;
        start_cmd(a, 1'b1);
        xfer(8'h00, r);
        desel();
        chk(r === exp, req, "read byte", int'(r), int'(exp));
    endtask

    task automatic t_powerup();
        logic [7:0] r;
        xfer(8'h06, r);
        cs_n = 1'b1;
        wclk(24);
        chk(n_wren == 0, "R1", "latch set without select edge", n_wren, 0);
        chk(so_oe == 1'b0, "R1", "so_oe while deselected", so_oe, 0);
        chk(!cmt_valid && !wrdi_pulse, "R1", "pulses after reset", cmt_valid, 0);
    endtask

    task automatic t_latch();
        logic [7:0] r;
        sel(); xfer(8'h06, r); desel();
        chk(n_wren == 1, "R7", "wren count", n_wren, 1);
        sel(); xfer(8'h04, r); desel();
        chk(n_wrdi == 1, "R7", "wrdi count", n_wrdi, 1);
        sel(); xfer(8'h06, r); xbits(8'h00, 1, r); desel();
        chk(n_wren == 1, "R7", "wren with extra bit", n_wren, 1);
    endtask

    task automatic t_write_read();
        logic [7:0] r0, r1, r2;
        int c0 = n_cmt;
        wr_grant = 1'b1;
        start_cmd(9'h123, 1'b0);
        xfer(8'hAA, r0); xfer(8'h55, r0); xfer(8'h3C, r0);
        desel();
        chk(n_cmt == c0 + 1, "R4", "commit count", n_cmt, c0 + 1);
        chk(last_st == 1'b0, "R4", "commit kind", last_st, 0);
        chk(last_addr == 9'h123, "R4", "commit address", last_addr, 9'h123);
        start_cmd(9'h123, 1'b1);
        xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2);
        desel();
        chk(r0 === 8'hAA, "R2", "first byte with high address bit", r0, 8'hAA);
        chk(r1 === 8'h55, "R2", "second byte", r1, 8'h55);
        chk(r2 === 8'h3C, "R2", "third byte", r2, 8'h3C);
    endtask

    task automatic t_page_wrap();
        logic [7:0] r;
        wr_grant = 1'b1;
        start_cmd(9'h05E, 1'b0);
        for (int k = 0; k < 18; k++) xfer(8'h80 + 8'(k), r);
        desel();
        start_cmd(9'h050, 1'b1);
        for (int o = 0; o < 16; o++) begin
            logic [7:0] e;
            e = (o >= 14) ? 8'h80 + 8'(o + 2) : 8'h80 + 8'(o + 2);
            if (o == 14) e = 8'h80 + 8'd16;
            if (o == 15) e = 8'h80 + 8'd17;
            xfer(8'h00, r);
            chk(r === e, "R4", "page wrap byte", int'(r), int'(e));
        end
        desel();
    endtask

    task automatic t_read_wrap();
        logic [7:0] r;
        logic [7:0] exp [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr_grant = 1'b1;
        start_cmd(9'h1FE, 1'b0); xfer(8'h11, r); xfer(8'h22, r); desel();
        start_cmd(9'h000, 1'b0); xfer(8'h33, r); xfer(8'h44, r); desel();
        start_cmd(9'h1FE, 1'b1);
        for (int i = 0; i < 4; i++) begin
            xfer(8'h00, r);
            chk(r === exp[i], "R3", "read across top of array", int'(r), int'(exp[i]));
        end
        desel();
    endtask

    task automatic t_abort();
        logic [7:0] r;
        int c0;
        wr_grant = 1'b1;
        write1(9'h010, 8'h77);
        c0 = n_cmt;
        start_cmd(9'h010, 1'b0);
        xfer(8'h99, r);
        xbits(8'hF0, 4, r);
        desel();
        chk(n_cmt == c0, "R5", "commit after mid-byte deselect", n_cmt, c0);
        expect_read(9'h010, 8'h77, "R5");
    endtask

    task automatic t_nogrant();
        int c0;
        wr_grant = 1'b1;
        write1(9'h020, 8'h12);
        c0 = n_cmt;
        wr_grant = 1'b0;
        write1(9'h020, 8'hEE);
        chk(n_cmt == c0 + 1, "R11", "strobe without grant", n_cmt, c0 + 1);
        wr_grant = 1'b1;
        expect_read(9'h020, 8'h12, "R11");
    endtask

    task automatic t_status_write();
        logic [7:0] r;
        int c0 = n_cmt;
        sel(); xfer(8'h01, r); xfer(8'h8C, r); desel();
        chk(n_cmt == c0 + 1, "R6", "status commit count", n_cmt, c0 + 1);
        chk(last_st == 1'b1, "R6", "status commit kind", last_st, 1);
        chk(last_sd == 8'h8C, "R6", "status commit byte", last_sd, 8'h8C);
        sel(); xfer(8'h01, r); xbits(8'hA0, 3, r); desel();
        chk(n_cmt == c0 + 1, "R6", "partial status byte", n_cmt, c0 + 1);
        sel(); xfer(8'h01, r); xfer(8'h8C, r); xbits(8'h00, 1, r); desel();
        chk(n_cmt == c0 + 1, "R6", "extra bit after status byte", n_cmt, c0 + 1);
    endtask

    task automatic t_busy();
        logic [7:0] r0, r1;
        wip = 1'b1;
        status_in = 8'h0D;
        sel(); xfer(8'h05, r0); xfer(8'h00, r0); xfer(8'h00, r1); desel();
        chk(r0 === 8'h0D, "R8", "status byte during write cycle", int'(r0), 8'h0D);
        chk(r1 === 8'h0D, "R8", "repeated status byte", int'(r1), 8'h0D);
        start_cmd(9'h123, 1'b1);
        xfer(8'h00, r0); xfer(8'h00, r0);
        chk(!oe_seen, "R9", "output enabled for refused read", oe_seen, 0);
        desel();
        wip = 1'b0;
    endtask

    task automatic t_unknown();
        logic [7:0] r;
        int w0 = n_wren, d0 = n_wrdi, c0 = n_cmt;
        sel(); xfer(8'hFF, r); xfer(8'h00, r); xfer(8'h00, r);
        chk(!oe_seen, "R10", "output enabled for unknown command", oe_seen, 0);
        desel();
        chk(n_wren + n_wrdi + n_cmt == w0 + d0 + c0, "R10", "pulses for unknown command",
            n_wren + n_wrdi + n_cmt, w0 + d0 + c0);
    endtask

    initial begin
        wclk(100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0;
        wip = 1'b0; wr_grant = 1'b0; status_in = 8'h00;
        wclk(8);
        rst_n = 1'b1;
        wclk(8);
        t_powerup();
        t_latch();
        t_write_read();
        t_page_wrap();
        t_read_wrap();
        t_abort();
        t_nogrant();
        t_status_write();
        t_busy();
        t_unknown();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule